// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Port

This block moves 16-bit words between a processor core and a synchronous serial link, such as a codec or a neighbouring processor. The core writes a transmit word into a holding buffer and reads received words from a receive buffer. Behind each buffer sits a shift register. Because of this split, the next word can wait in the buffer while the current one is being shifted. Words then follow each other on the wire with no idle bit period between them.

The port generates its own bit clock from the core clock at one of four rates. It marks the start of every word with a frame-sync pulse one bit period wide. Status flags tell the core when the transmit buffer can take a word, when a received word is waiting, and when a received word was lost to overwriting. A bit-order control picks most-significant-first or least-significant-first shifting. An optional addressed mode lets up to eight ports share one link: a port keeps only the words whose top three bits equal its own address.

The receive side samples separate clock, frame and data pins through synchronisers. It can therefore listen to any port's transmit pins, including its own.

Top module: `ssp_port`

## Requirements
- R1: After reset, obe is 1, ibf is 0, ovr is 0, and sclk_o, fs_o and sd_o are all 0.
- R2: A tx_wr pulse makes obe read 0 in the following cycle. obe returns to 1 when the word moves into the shift register, which is the bit period in which its frame-sync pulse is driven.
- R3: A received word that is accepted sets ibf and appears on rx_rdata. An rx_rd pulse clears both ibf and ovr in the next cycle, unless a new word is accepted in that same cycle.
- R4: The ctl_wdata[1:0] rate code r sets the sclk_o period to 2*(r+1) core clock cycles, which gives dividers of 2, 4, 6 and 8.
- R5: fs_o is high for exactly one bit period. The first data bit of the word is driven in the bit period that follows it. Outputs change on falling sclk_o edges, and the receiver samples on rising edges.
- R6: When the next word is written before the current word's last two bits, consecutive fs_o pulses are exactly 16 bit periods apart. The next word's frame-sync pulse overlaps the current word's last data bit.
- R7: ctl_wdata[2] = 0 shifts bit 15 first, and ctl_wdata[2] = 1 shifts bit 0 first. A word looped back through the receiver with the same setting arrives unchanged.
- R8: With ctl_wdata[3] = 1 (addressed mode), the receiver accepts a word only when its bits [15:13] equal ctl_wdata[6:4]. A word that does not match leaves ibf and rx_rdata unchanged.
- R9: When a word is accepted while ibf is still set, the word replaces rx_rdata and ovr becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 7 | Control value: [1:0] rate, [2] LSB first, [3] addressed mode, [6:4] own address |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_wdata | input | 16 | Transmit word |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_rdata | output | 16 | Receive buffer contents |
| obe | output | 1 | Transmit buffer is empty |
| ibf | output | 1 | Receive buffer holds an unread word |
| ovr | output | 1 | A received word overwrote an unread one |
| sclk_o | output | 1 | Generated bit clock |
| fs_o | output | 1 | Transmit frame sync |
| sd_o | output | 1 | Transmit serial data |
| sclk_i | input | 1 | Receive bit clock |
| fs_i | input | 1 | Receive frame sync |
| sd_i | input | 1 | Receive serial data |

## Verification
The transmit pins are looped back to the receive pins. Words are sent under four conditions:
- **Single, widely spaced words.** These exercise the basic framing.
- **Refilled bursts.** Each word is written as soon as obe rises. The fs_o spacing then shows whether the double buffering really removes the idle gap.
- **Asymmetric patterns in both bit orders.** A decoder in the bench reads the raw pin stream. This catches a reversed order that a loopback alone would hide.
- **Addressed words with matching and non-matching headers, and unread bursts.** These separate the address filter from the overwrite and overrun path.

Clock rates are told apart by measuring the sclk_o period for each code.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
// Shared parameters and the control register layout for the serial port.
// Assumes a fixed 16-bit word and a 3-bit address carried in the word's top bits.
package ssp_pkg;
    parameter int SSP_WORD_W = 16;
    parameter int SSP_ADDR_W = 3;
    parameter int SSP_RATE_W = 2;

    typedef struct packed {
        logic [SSP_ADDR_W-1:0] own_addr;
        logic                  mp_en;
        logic                  lsb_first;
        logic [SSP_RATE_W-1:0] rate;
    } ssp_ctl_t;

    localparam int SSP_CTL_W = $bits(ssp_ctl_t);
endpackage

// File: rtl/ssp_clkgen.sv
`timescale 1ns/1ps
// Bit clock generator: toggles sclk every (rate+1) core cycles,
// giving a bit clock of clk/(2*(rate+1)).
// Assumes that a rate change may stretch one half period at most.
module ssp_clkgen #(
    parameter int RATE_W = ssp_pkg::SSP_RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic              sclk_o,
    output logic              rise_tick,
    output logic              fall_tick
);
    logic [RATE_W-1:0] cnt_q;
    logic              wrap;

    assign wrap      = (cnt_q >= rate);
    assign rise_tick = wrap && !sclk_o;
    assign fall_tick = wrap && sclk_o;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_o <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            sclk_o <= ~sclk_o;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assert_rise_sets_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> sclk_o);
    assert_fall_clears_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |=> !sclk_o);
endmodule

// File: rtl/ssp_tx.sv
`timescale 1ns/1ps
// Transmit path: a holding buffer feeds a shift register.
// The next word is claimed during the current word's last bit period,
// so that its frame sync overlaps that bit and words run back to back.
// Assumes fall_tick marks each falling edge of the generated bit clock.
module ssp_tx #(
    parameter int WORD_W = ssp_pkg::SSP_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_tick,
    input  logic              lsb_first,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_wdata,
    output logic              obe,
    output logic              fs_o,
    output logic              sd_o
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] hold_q, next_q, shreg_q;
    logic              full_q, armed_q, active_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic              claim;

    function automatic logic pick_bit(input logic [WORD_W-1:0] w, input logic lsb);
        return lsb ? w[0] : w[WORD_W-1];
    endfunction

    function automatic logic [WORD_W-1:0] shift_word(input logic [WORD_W-1:0] w, input logic lsb);
        return lsb ? {1'b0, w[WORD_W-1:1]} : {w[WORD_W-2:0], 1'b0};
    endfunction

    assign claim = fall_tick && full_q && !armed_q && (!active_q || bitcnt_q >= LAST - 1'b1);
    assign obe   = !full_q;

    // Holding buffer: loaded by the core, emptied when the shifter claims it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            full_q <= 1'b0;
        end else if (tx_wr) begin
            hold_q <= tx_wdata;
            full_q <= 1'b1;
        end else if (claim) begin
            full_q <= 1'b0;
        end
    end

    // Frame sync, shift register and bit counter, all advancing on falling bit-clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q   <= '0;
            shreg_q  <= '0;
            fs_o     <= 1'b0;
            sd_o     <= 1'b0;
            armed_q  <= 1'b0;
            active_q <= 1'b0;
            bitcnt_q <= '0;
        end else if (fall_tick) begin
            if (claim) begin
                fs_o    <= 1'b1;
                armed_q <= 1'b1;
                next_q  <= hold_q;
            end
            if (armed_q) begin
                fs_o     <= 1'b0;
                armed_q  <= 1'b0;
                active_q <= 1'b1;
                bitcnt_q <= '0;
                sd_o     <= pick_bit(next_q, lsb_first);
                shreg_q  <= shift_word(next_q, lsb_first);
            end else if (active_q) begin
                if (bitcnt_q == LAST) begin
                    active_q <= 1'b0;
                    sd_o     <= 1'b0;
                end else begin
                    bitcnt_q <= bitcnt_q + 1'b1;
                    sd_o     <= pick_bit(shreg_q, lsb_first);
                    shreg_q  <= shift_word(shreg_q, lsb_first);
                end
            end
        end
    end

    assert_obe_low_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !obe);
    assert_fs_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_o && fall_tick) |=> !fs_o);
    assert_fs_marks_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_o) |-> $past(full_q));
endmodule

// File: rtl/ssp_rx.sv
`timescale 1ns/1ps
// Receive path: synchronises the incoming clock, frame and data pins,
// shifts on rising clock edges and delivers complete words to a receive buffer,
// applying the address filter and overrun detection.
// Assumes the incoming bit clock is at most half the core clock rate.
module ssp_rx #(
    parameter int WORD_W = ssp_pkg::SSP_WORD_W,
    parameter int ADDR_W = ssp_pkg::SSP_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              fs_i,
    input  logic              sd_i,
    input  logic              lsb_first,
    input  logic              mp_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_rdata,
    output logic              ibf,
    output logic              ovr
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [2:0]        s1_q, s2_q;
    logic              sclk_prev_q;
    logic              s_sclk, s_fs, s_sd, rise;
    logic [WORD_W-1:0] sh_q, sh_in;
    logic [CNT_W-1:0]  cnt_q;
    logic              start_q, active_q;
    logic              done, addr_ok, accept;

    assign {s_sclk, s_fs, s_sd} = s2_q;
    assign rise    = s_sclk && !sclk_prev_q;
    assign sh_in   = lsb_first ? {s_sd, sh_q[WORD_W-1:1]} : {sh_q[WORD_W-2:0], s_sd};
    assign done    = rise && active_q && !start_q && (cnt_q == LAST);
    assign addr_ok = !mp_en || (sh_in[WORD_W-1 -: ADDR_W] == own_addr);
    assign accept  = done && addr_ok;

    // Two-stage synchronisers on the serial pins plus an edge-detect history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q        <= '0;
            s2_q        <= '0;
            sclk_prev_q <= 1'b0;
        end else begin
            s1_q        <= {sclk_i, fs_i, sd_i};
            s2_q        <= s1_q;
            sclk_prev_q <= s_sclk;
        end
    end

    // Shift register and bit counter, advancing on rising bit-clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            start_q  <= 1'b0;
            active_q <= 1'b0;
        end else if (rise) begin
            if (start_q || active_q)
                sh_q <= sh_in;
            if (start_q) begin
                active_q <= 1'b1;
                cnt_q    <= CNT_W'(1);
            end else if (active_q) begin
                if (cnt_q == LAST)
                    active_q <= 1'b0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
            start_q <= s_fs;
        end
    end

    // Receive buffer with full and overrun flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_rdata <= '0;
            ibf      <= 1'b0;
            ovr      <= 1'b0;
        end else if (accept) begin
            rx_rdata <= sh_in;
            ibf      <= 1'b1;
            if (ibf && !rx_rd)
                ovr <= 1'b1;
            else if (rx_rd)
                ovr <= 1'b0;
        end else if (rx_rd) begin
            ibf <= 1'b0;
            ovr <= 1'b0;
        end
    end

    assert_read_clears_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !accept) |=> (!ibf && !ovr));
    assert_accept_sets_ibf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ibf);
    assert_ovr_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(ibf));
    assert_mismatch_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !addr_ok && !rx_rd) |=> ($stable(rx_rdata) && $stable(ibf)));
endmodule

// File: rtl/ssp_port.sv
`timescale 1ns/1ps
// Double-buffered synchronous serial port top.
// It holds the control register and ties together the bit clock generator,
// the transmit path and the receive path.
// Assumes single-cycle write and read strobes from the core.
module ssp_port
    import ssp_pkg::*;
#(
    parameter int WORD_W = SSP_WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_wr,
    input  logic [SSP_CTL_W-1:0] ctl_wdata,
    input  logic                 tx_wr,
    input  logic [WORD_W-1:0]    tx_wdata,
    input  logic                 rx_rd,
    output logic [WORD_W-1:0]    rx_rdata,
    output logic                 obe,
    output logic                 ibf,
    output logic                 ovr,
    output logic                 sclk_o,
    output logic                 fs_o,
    output logic                 sd_o,
    input  logic                 sclk_i,
    input  logic                 fs_i,
    input  logic                 sd_i
);
    ssp_ctl_t ctl_q;
    logic     rise_tick, fall_tick;

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (ctl_wr)
            ctl_q <= ssp_ctl_t'(ctl_wdata);
    end

    ssp_clkgen #(.RATE_W(SSP_RATE_W)) clkgen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate      (ctl_q.rate),
        .sclk_o    (sclk_o),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    ssp_tx #(.WORD_W(WORD_W)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_tick (fall_tick),
        .lsb_first (ctl_q.lsb_first),
        .tx_wr     (tx_wr),
        .tx_wdata  (tx_wdata),
        .obe       (obe),
        .fs_o      (fs_o),
        .sd_o      (sd_o)
    );

    ssp_rx #(.WORD_W(WORD_W), .ADDR_W(SSP_ADDR_W)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk_i),
        .fs_i      (fs_i),
        .sd_i      (sd_i),
        .lsb_first (ctl_q.lsb_first),
        .mp_en     (ctl_q.mp_en),
        .own_addr  (ctl_q.own_addr),
        .rx_rd     (rx_rd),
        .rx_rdata  (rx_rdata),
        .ibf       (ibf),
        .ovr       (ovr)
    );

    assert_fs_on_falling_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(fs_o) |-> $fell(sclk_o));
    assert_sd_on_falling_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sd_o) |-> $fell(sclk_o));
endmodule

// File: tb/ssp_port_tb_top.sv
`timescale 1ns/1ps
module ssp_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [6:0]  ctl_wdata = '0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        mon_rd = 1'b0, man_rd = 1'b0;
    logic        rx_rd;
    logic [15:0] rx_rdata;
    logic        obe, ibf, ovr, sclk_o, fs_o, sd_o;

    always #5 clk = ~clk;
    assign rx_rd = mon_rd | man_rd;

    ssp_port dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .obe(obe), .ibf(ibf), .ovr(ovr), .sclk_o(sclk_o), .fs_o(fs_o), .sd_o(sd_o),
        .sclk_i(sclk_o), .fs_i(fs_o), .sd_i(sd_o)
    );

    int          total = 0, bad = 0;
    int          cyc = 0, last_fs = 0, last_gap = 0;
    logic [15:0] txq[$], rxq[$];
    bit          auto_rd = 1'b1;
    bit          lsb_mode = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rev16(input logic [15:0] w);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = w[15-i];
        return r;
    endfunction

    always @(posedge clk) cyc++;

    // fs spacing in core cycles (R6)
    always @(posedge fs_o) begin
        last_gap = cyc - last_fs;
        last_fs  = cyc;
    end

    // Pin-level decoder: rebuilds each word in arrival order (R5, R7)
    bit          s_start = 0, s_act = 0;
    int          s_cnt = 0;
    logic [15:0] s_raw = '0;
    always @(posedge sclk_o) begin
        if (s_start || s_act) s_raw = {s_raw[14:0], sd_o};
        if (s_start) begin
            s_act = 1; s_cnt = 1;
        end else if (s_act) begin
            if (s_cnt == 15) begin
                logic [15:0] e;
                s_act = 0;
                if (txq.size() == 0) chk(0, "R5 unexpected frame", s_raw, 0);
                else begin
                    e = txq.pop_front();
                    if (lsb_mode) e = rev16(e);
                    chk(s_raw == e, "R7 pin bit order", s_raw, e);
                end
            end else s_cnt++;
        end
        s_start = fs_o;
    end

    // Receive scoreboard monitor (R3)
    always @(negedge clk) begin
        if (!rst_n) mon_rd = 0;
        else if (mon_rd) mon_rd = 0;
        else if (auto_rd && ibf) begin
            logic [15:0] e;
            if (rxq.size() == 0) chk(0, "R8 unexpected receive", rx_rdata, 0);
            else begin
                e = rxq.pop_front();
                chk(rx_rdata == e, "R3 received word", rx_rdata, e);
            end
            mon_rd = 1;
        end
    end

    task automatic set_ctl(input logic [2:0] a, input bit mp, input bit lsb, input logic [1:0] r);
        @(negedge clk);
        ctl_wdata = {a, mp, lsb, r};
        ctl_wr = 1;
        @(negedge clk);
        ctl_wr = 0;
        lsb_mode = lsb;
    endtask

    task automatic send(input logic [15:0] w, input bit expect_rx);
        while (!obe) @(negedge clk);
        tx_wdata = w;
        tx_wr = 1;
        txq.push_back(w);
        if (expect_rx) rxq.push_back(w);
        @(negedge clk);
        tx_wr = 0;
    endtask

    task automatic drain();
        while (txq.size() != 0) @(negedge clk);
        repeat (60) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(obe == 1, "R1 obe", obe, 1);
        chk(ibf == 0, "R1 ibf", ibf, 0);
        chk(ovr == 0, "R1 ovr", ovr, 0);
        chk(fs_o == 0 && sd_o == 0, "R1 fs/sd", {fs_o, sd_o}, 0);

        // R4 clock rates
        for (int r = 0; r < 4; r++) begin
            int t0;
            set_ctl(3'd0, 0, 0, 2'(r));
            @(posedge sclk_o); @(posedge sclk_o);
            t0 = cyc;
            @(posedge sclk_o);
            chk(cyc - t0 == 2 * (r + 1), "R4 sclk period", cyc - t0, 2 * (r + 1));
        end

        // R2 obe clears after write, sets again when claimed
        set_ctl(3'd0, 0, 0, 2'd1);
        @(negedge clk);
        tx_wdata = 16'hC3A5; tx_wr = 1;
        txq.push_back(16'hC3A5); rxq.push_back(16'hC3A5);
        @(negedge clk);
        tx_wr = 0;
        chk(obe == 0, "R2 obe after write", obe, 0);
        while (!fs_o) @(negedge clk);
        chk(obe == 1, "R2 obe during frame sync", obe, 1);
        drain();

        // R6 back-to-back, MSB first
        send(16'h1234, 1); send(16'hF00D, 1); send(16'h8001, 1); send(16'h7E5A, 1);
        drain();
        chk(last_gap == 16 * 4, "R6 fs spacing", last_gap, 64);

        // R7 LSB first, rate 2
        set_ctl(3'd0, 0, 1, 2'd2);
        send(16'h0001, 1); send(16'hA5C3, 1); send(16'h8000, 1);
        drain();
        chk(last_gap == 16 * 6, "R6 fs spacing lsb", last_gap, 96);

        // R8 addressed mode, own address 5
        set_ctl(3'd5, 1, 0, 2'd0);
        send(16'hA123, 1);
        drain();
        send(16'h6ABC, 0);
        drain();
        chk(ibf == 0, "R8 mismatch ibf", ibf, 0);
        chk(rx_rdata == 16'hA123, "R8 mismatch rdata", rx_rdata, 16'hA123);
        send(16'hB00F, 1);
        drain();

        // R9 overrun with reads held off
        set_ctl(3'd0, 0, 0, 2'd0);
        auto_rd = 0;
        send(16'h1111, 0); send(16'h2222, 0);
        drain();
        chk(ibf == 1, "R9 ibf", ibf, 1);
        chk(ovr == 1, "R9 ovr", ovr, 1);
        chk(rx_rdata == 16'h2222, "R9 overwrite", rx_rdata, 16'h2222);
        @(negedge clk); man_rd = 1;
        @(negedge clk); man_rd = 0;
        chk(ibf == 0 && ovr == 0, "R3 read clears flags", {ibf, ovr}, 0);
        auto_rd = 1;

        chk(txq.size() == 0, "R5 all frames seen", txq.size(), 0);
        chk(rxq.size() == 0, "R3 all words received", rxq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule